// File: doc/BRIEF.md
# Down-Counting Interval Timer with Word Register Bus

This block is a 32-bit interval timer that sits on a simple word-addressed register bus. Software programs a reload period and a control word. While the run bit is set, a 32-bit counter steps down once on every clock edge where the `tick` enable is high. When the counter is zero on a running tick, it either reloads from the period or stays at zero. An interrupt pulse is raised each time a running tick leaves the counter at zero with reload enabled.

There are four word registers. A free general-purpose store sits at offset 0x0. The control word is at 0x4: bit 2 runs the counter, and bit 0 enables both auto-reload and the interrupt. The reload period is at 0x8. A read-only view of the live counter is at 0xC. Writing the period never loads the counter directly, so a timer started from a zero count picks up the period on its first running tick.

The bus takes full 4-byte accesses only. The byte order on the data lanes is big-endian: lane 0 (`[7:0]`) carries the register's most significant byte. A bad access returns an error strobe one cycle after the request.

The bus response is handled by a small state machine with four states:
- `BS_IDLE`: no request.
- `BS_READ`: a legal read was taken last cycle.
- `BS_WRITE`: a legal write was taken last cycle.
- `BS_ERROR`: an illegal access was rejected last cycle.

On every clock edge the state goes to `BS_IDLE` when `bus_valid` is low. With `bus_valid` high it goes to `BS_READ` or `BS_WRITE` for a legal access, and to `BS_ERROR` otherwise. Any state may move to any state.

Top module: `interval_timer`

## Requirements
- R1: After reset, the four registers are all zero, and `irq`, `bus_ack`, `bus_err` and `bus_rdata` are all zero.
- R2: A legal access at a word offset of 0x0, 0x4 or 0x8 (or a read at 0xC) gives `bus_ack` high for exactly the cycle after the request. Register value bits [31:24] travel on data bits [7:0], bits [23:16] on [15:8], and so on, for both writes and read data.
- R3: The counter changes only on clock edges where `tick` is high and control bit 2 was already set before that edge.
- R4: On a running tick, a nonzero counter decreases by one.
- R5: On a running tick with the counter at zero, the counter takes the period value if control bit 0 is set, and stays at zero if bit 0 is clear.
- R6: `irq` is high for the one cycle after a running tick whose updated counter is zero while control bit 0 is set, and low after every other edge.
- R7: A control write that sets bit 2 in the same cycle as a tick does not make that tick count; counting starts on the next tick.
- R8: Writing the period does not change the counter.
- R9: A write to offset 0xC is rejected with `bus_err` and leaves the counter unchanged.
- R10: An access with `bus_size` other than 4 gives `bus_err` the next cycle, with no `bus_ack`, no register change and zero `bus_rdata`.
- R11: An access at an offset that is not one of 0x0, 0x4, 0x8 or 0xC gives `bus_err` for one cycle and zero `bus_rdata`, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable |
| bus_valid | input | 1 | Request strobe, one access per cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset within the block |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data, big-endian lanes |
| bus_rdata | output | 32 | Read data, big-endian lanes, valid with bus_ack |
| bus_ack | output | 1 | Legal access completed (cycle after request) |
| bus_err | output | 1 | Access rejected (cycle after request) |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume that `tick` and all bus inputs change only away from the rising edge and are free of X or Z after reset. They also assume at most one request per cycle. The interrupt check assumes that `irq` can only follow a sampled `tick`.

The bench drives every input on the falling edge and holds it for a single full cycle. It raises `tick` only inside its own tasks, never between a request and its sampled response, and it reads the counter only through offset 0xC.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned SIZE_W  = 3;

    localparam logic [ADDR_W-1:0] OFS_SCRATCH = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_PERIOD  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 4'hC;

    localparam int unsigned CTRL_RELOAD_BIT = 0;
    localparam int unsigned CTRL_RUN_BIT    = 2;

    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_READ  = 2'd1,
        BS_WRITE = 2'd2,
        BS_ERROR = 2'd3
    } bus_state_t;

endpackage

// File: rtl/tmr_lane_swap.sv
module tmr_lane_swap #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LANES = WIDTH / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[8*g +: 8] = din[8*(LANES-1-g) +: 8];
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             reload_en,
    input  logic [WIDTH-1:0] period,
    output logic [WIDTH-1:0] count,
    output logic             irq
);
    logic [WIDTH-1:0] cnt_q, cnt_d;
    logic             irq_q, irq_d;
    logic             step;

    assign step = tick && run;

    always_comb begin
        cnt_d = cnt_q;
        if (step) begin
            if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end else if (reload_en) begin
                cnt_d = period;
            end
        end
        irq_d = step && reload_en && (cnt_d == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= irq_d;
        end
    end

    assign count = cnt_q;
    assign irq   = irq_q;

    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(tick)); // R6
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q)); // R3
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q)); // R3
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import timer_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned SW = SIZE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [SW-1:0] bus_size,
    input  logic [DW-1:0] wr_value,
    input  logic [DW-1:0] cnt_value,
    output logic [DW-1:0] rd_value,
    output logic [DW-1:0] period,
    output logic          run,
    output logic          reload_en,
    output logic          bus_ack,
    output logic          bus_err
);
    localparam logic [SW-1:0] FULL_BYTES = SW'(DW / 8);

    bus_state_t    state_q, state_d;
    logic [DW-1:0] scratch_q, ctrl_q, period_q, rd_q, sel_value;
    logic          size_ok, rd_ok, wr_ok;

    // Access legality and read selection
    always_comb begin
        size_ok   = (bus_size == FULL_BYTES);
        rd_ok     = 1'b0;
        wr_ok     = 1'b0;
        sel_value = '0;
        unique case (bus_addr)
            OFS_SCRATCH: begin sel_value = scratch_q; rd_ok = 1'b1; wr_ok = 1'b1; end
            OFS_CTRL:    begin sel_value = ctrl_q;    rd_ok = 1'b1; wr_ok = 1'b1; end
            OFS_PERIOD:  begin sel_value = period_q;  rd_ok = 1'b1; wr_ok = 1'b1; end
            OFS_COUNT:   begin sel_value = cnt_value; rd_ok = 1'b1; end
            default:     begin sel_value = '0; end
        endcase
        rd_ok = rd_ok && size_ok && !bus_write;
        wr_ok = wr_ok && size_ok && bus_write;
    end

    // Next-state logic
    always_comb begin
        state_d = BS_IDLE;
        if (bus_valid) begin
            if (wr_ok)      state_d = BS_WRITE;
            else if (rd_ok) state_d = BS_READ;
            else            state_d = BS_ERROR;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    // Register file and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            ctrl_q    <= '0;
            period_q  <= '0;
            rd_q      <= '0;
        end else begin
            rd_q <= (bus_valid && rd_ok) ? sel_value : '0;
            if (bus_valid && wr_ok) begin
                unique case (bus_addr)
                    OFS_SCRATCH: scratch_q <= wr_value;
                    OFS_CTRL:    ctrl_q    <= wr_value;
                    OFS_PERIOD:  period_q  <= wr_value;
                    default:     ;
                endcase
            end
        end
    end

    // Output decode from state
    always_comb begin
        bus_ack = 1'b0;
        bus_err = 1'b0;
        unique case (state_q)
            BS_IDLE:  ;
            BS_READ:  bus_ack = 1'b1;
            BS_WRITE: bus_ack = 1'b1;
            BS_ERROR: bus_err = 1'b1;
            default:  ;
        endcase
    end

    assign rd_value  = rd_q;
    assign period    = period_q;
    assign run       = ctrl_q[CTRL_RUN_BIT];
    assign reload_en = ctrl_q[CTRL_RELOAD_BIT];

    AST_ERR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !bus_ack); // R10
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (rd_q == '0)); // R11
    AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_size != FULL_BYTES) |=> bus_err); // R10
    AST_COUNT_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFS_COUNT) |=> bus_err); // R9
    AST_PERIOD_STABLE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size != FULL_BYTES) |=> $stable(period_q)); // R10

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [SIZE_W-1:0]   bus_size,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ack,
    output logic                bus_err,
    output logic                irq
);
    logic [DATA_W-1:0] wr_value, rd_value, period, count;
    logic              run, reload_en;

    tmr_lane_swap #(.WIDTH(DATA_W)) u_wr_swap (.din(bus_wdata), .dout(wr_value));
    tmr_lane_swap #(.WIDTH(DATA_W)) u_rd_swap (.din(rd_value),  .dout(bus_rdata));

    tmr_regs #(.DW(DATA_W), .AW(ADDR_W), .SW(SIZE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .wr_value  (wr_value),
        .cnt_value (count),
        .rd_value  (rd_value),
        .period    (period),
        .run       (run),
        .reload_en (reload_en),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err)
    );

    tmr_counter #(.WIDTH(DATA_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (run),
        .reload_en (reload_en),
        .period    (period),
        .count     (count),
        .irq       (irq)
    );

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_err)); // R2
    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (!bus_ack && !bus_err)); // R2

endmodule

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack, bus_err, irq;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq)
    );

    // {write, addr, size, wdata, expected rdata, expected err}
    localparam int NV = 12;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 4'h0, 3'd4, 32'hA1B2C3D4, 32'h0,        1'b0}, // R2 write store
        {1'b0, 4'h0, 3'd4, 32'h0,        32'hA1B2C3D4, 1'b0}, // R2 read back
        {1'b1, 4'h8, 3'd2, 32'hFFFFFFFF, 32'h0,        1'b1}, // R10 half write
        {1'b0, 4'h8, 3'd4, 32'h0,        32'h0,        1'b0}, // R10 period untouched
        {1'b1, 4'hC, 3'd4, 32'h07000000, 32'h0,        1'b1}, // R9 write count
        {1'b0, 4'hC, 3'd4, 32'h0,        32'h0,        1'b0}, // R9 count unchanged
        {1'b0, 4'h3, 3'd4, 32'h0,        32'h0,        1'b1}, // R11 odd offset read
        {1'b0, 4'h0, 3'd1, 32'h0,        32'h0,        1'b1}, // R10 byte read
        {1'b1, 4'h6, 3'd4, 32'h00000001, 32'h0,        1'b1}, // R11 odd offset write
        {1'b0, 4'h4, 3'd4, 32'h0,        32'h0,        1'b0}, // R11 control untouched
        {1'b1, 4'h4, 3'd3, 32'h05000000, 32'h0,        1'b1}, // R10 3-byte write
        {1'b0, 4'h4, 3'd4, 32'h0,        32'h0,        1'b0}  // R10 control untouched
    };

    function automatic logic [31:0] be(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic op(input logic wr, input logic [3:0] a, input logic [2:0] sz,
                      input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz;
        bus_wdata = d; tick = tk;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; tick = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic read_count(input string tag, input logic [31:0] exp_val);
        op(1'b0, 4'hC, 3'd4, 32'h0, 1'b0);
        check(tag, bus_rdata, be(exp_val));
        check(tag, {31'b0, bus_ack}, 32'd1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=%0d expected<=50000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 ack", {31'b0, bus_ack}, 32'd0);
        check("R1 err", {31'b0, bus_err}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        for (int a = 0; a < 16; a += 4) begin
            op(1'b0, 4'(a), 3'd4, 32'h0, 1'b0);
            check("R1 register zero", bus_rdata, 32'd0);
        end

        // Table walk
        for (int i = 0; i < NV; i++) begin
            op(VEC[i][72], VEC[i][71:68], VEC[i][67:65], VEC[i][64:33], 1'b0);
            check($sformatf("R2/R9/R10/R11 vec %0d err", i), {31'b0, bus_err}, {31'b0, VEC[i][0]});
            check($sformatf("R2/R9/R10/R11 vec %0d ack", i), {31'b0, bus_ack}, {31'b0, ~VEC[i][0]});
            check($sformatf("R2/R10/R11 vec %0d rdata", i), bus_rdata, VEC[i][32:1]);
        end

        // Period write leaves the counter alone
        op(1'b1, 4'h8, 3'd4, be(32'd5), 1'b0);
        read_count("R8 count after period write", 32'd0);
        op(1'b0, 4'h8, 3'd4, 32'h0, 1'b0);
        check("R2 period lanes", bus_rdata, 32'h05000000);

        // Ticks while stopped
        repeat (3) pulse_tick();
        read_count("R3 stopped", 32'd0);

        // Start with a tick in the same cycle
        op(1'b1, 4'h4, 3'd4, be(32'd5), 1'b1);
        check("R7 no irq on start", {31'b0, irq}, 32'd0);
        read_count("R7 same-cycle tick ignored", 32'd0);

        pulse_tick();
        check("R6 no irq on reload", {31'b0, irq}, 32'd0);
        read_count("R5 reload from period", 32'd5);
        for (int k = 1; k <= 4; k++) begin
            pulse_tick();
            check("R6 no irq mid count", {31'b0, irq}, 32'd0);
            read_count("R4 decrement", 32'(5 - k));
        end
        pulse_tick();
        check("R6 irq on reaching zero", {31'b0, irq}, 32'd1);
        @(negedge clk);
        check("R6 irq single cycle", {31'b0, irq}, 32'd0);
        read_count("R4 reached zero", 32'd0);
        repeat (3) @(negedge clk);
        read_count("R3 no tick no change", 32'd0);
        pulse_tick();
        read_count("R5 second reload", 32'd5);

        // Bit 0 clear: count to zero and hold, no irq
        op(1'b1, 4'h4, 3'd4, be(32'd4), 1'b0);
        for (int k = 0; k < 7; k++) begin
            pulse_tick();
            check("R6 no irq with bit0 clear", {31'b0, irq}, 32'd0);
        end
        read_count("R5 hold at zero", 32'd0);

        // Zero period with reload: irq on every running tick
        op(1'b1, 4'h8, 3'd4, 32'h0, 1'b0);
        op(1'b1, 4'h4, 3'd4, be(32'd5), 1'b0);
        pulse_tick();
        check("R6 zero period irq", {31'b0, irq}, 32'd1);
        pulse_tick();
        check("R6 zero period irq again", {31'b0, irq}, 32'd1);

        // Stop
        op(1'b1, 4'h4, 3'd4, 32'h0, 1'b0);
        pulse_tick();
        check("R3 stopped no irq", {31'b0, irq}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule